// File: doc/BRIEF.md
# Parallel Gardner Timing Error Averager with Loop Filter

This block is the error and loop-filter part of a parallel symbol timing recovery loop. In every clock it takes up to `N_CH` channels. Each channel carries three interpolated complex samples spaced half a symbol apart: the earlier symbol, the midpoint and the later symbol. For each channel it forms a Gardner timing error. It averages these errors across all channels and passes the average through a proportional-plus-integral filter. The result is one phase-step word per accepted input, which goes to the NCO that steers the interpolators.

The gains are shift amounts applied from two input ports, so the loop bandwidth can be set at run time without multipliers. The output word is a nominal step plus the filter output. The integrator saturates at its signed limits instead of wrapping. A synchronous clear returns it to zero after a lock loss.

Top module: `gardner_par_loop`

## Requirements
- R1: For each channel c, the samples occupy bits [c*W_SAMP +: W_SAMP] of every sample bus, as two's complement values. The channel error is mid_i*(cur_i-prev_i) + mid_q*(cur_q-prev_q), computed exactly in W_SAMP*2+2 bits.
- R2: The averaged error is the exact sum of all N_CH channel errors shifted right arithmetically by log2(N_CH), which rounds toward minus infinity (a sum of -1 gives -1). N_CH must be a power of two.
- R3: On each accepted average, the integrator adds the average shifted right arithmetically by `ki_shift`. The result is clamped to the signed range of W_INT bits rather than wrapped.
- R4: The output word equals `nominal_step` plus the average shifted right arithmetically by `kp_shift`, plus the integrator value after this update, taken modulo 2^W_OUT.
- R5: `out_valid` pulses for exactly one cycle, three rising edges after the edge that accepts `in_valid`. It never pulses otherwise.
- R6: `integ_clear` sampled high sets the integrator to zero. If an average reaches the filter on the same edge, its output uses a zero integrator and the integrator stays zero.
- R7: After reset, `out_valid` is 0, `out_step` is 0 and the integrator is zero.
- R8: Cycles with `in_valid` low change neither the integrator nor `out_step`, whatever the sample buses carry. This shows in the next valid output.
- R9: Inputs accepted on consecutive cycles each produce their own output, on consecutive cycles and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample buses hold a set of triples this cycle |
| prev_i | input | N_CH*W_SAMP | Earlier symbol, in-phase, per channel |
| prev_q | input | N_CH*W_SAMP | Earlier symbol, quadrature, per channel |
| mid_i | input | N_CH*W_SAMP | Half-symbol point, in-phase, per channel |
| mid_q | input | N_CH*W_SAMP | Half-symbol point, quadrature, per channel |
| cur_i | input | N_CH*W_SAMP | Later symbol, in-phase, per channel |
| cur_q | input | N_CH*W_SAMP | Later symbol, quadrature, per channel |
| kp_shift | input | W_SH | Proportional gain as right-shift amount |
| ki_shift | input | W_SH | Integral gain as right-shift amount |
| nominal_step | input | W_OUT | Free-running phase step added to the filter output |
| integ_clear | input | 1 | Synchronous integrator clear |
| out_valid | output | 1 | One-cycle strobe for a new step word |
| out_step | output | W_OUT | Phase-step word for the NCO |

## Verification
The results arrive at fixed times after an input is accepted. The channel errors are registered one edge later and the average two edges later. The step word and its strobe appear three edges later. When the bench drives an input, it records the cycle count at which the result is due along with the expected word. At each falling edge it compares the strobe against the front of that queue, so a result that comes early, late, twice or not at all is reported as an R5 failure, separately from a wrong value. Integrator clears are timed against that same count, so that one clear lands exactly on the edge where a chosen average reaches the filter.

// File: rtl/gted_pkg.sv
package gted_pkg;

    // True when n is a positive power of two.
    function automatic bit is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction

    // Width of a Gardner channel error for a given sample width.
    function automatic int err_width(input int w_samp);
        return 2 * w_samp + 2;
    endfunction

endpackage

// File: rtl/gted_channel.sv
module gted_channel #(
    parameter int W_SAMP = 12,
    localparam int W_DIFF = W_SAMP + 1,
    localparam int W_PROD = W_SAMP + W_DIFF,
    localparam int W_ERR  = gted_pkg::err_width(W_SAMP)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [W_SAMP-1:0] prev_i,
    input  logic signed [W_SAMP-1:0] prev_q,
    input  logic signed [W_SAMP-1:0] mid_i,
    input  logic signed [W_SAMP-1:0] mid_q,
    input  logic signed [W_SAMP-1:0] cur_i,
    input  logic signed [W_SAMP-1:0] cur_q,
    output logic signed [W_ERR-1:0]  err_q
);
    typedef struct packed {
        logic signed [W_ERR-1:0] err;
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic signed [W_DIFF-1:0] dif_i, dif_q;
    logic signed [W_PROD-1:0] prod_i, prod_q;

    always_comb begin
        st_d   = st_q;
        dif_i  = W_DIFF'(cur_i) - W_DIFF'(prev_i);
        dif_q  = W_DIFF'(cur_q) - W_DIFF'(prev_q);
        prod_i = W_PROD'(mid_i) * W_PROD'(dif_i);
        prod_q = W_PROD'(mid_q) * W_PROD'(dif_q);
        if (en) begin
            st_d.err = W_ERR'(prod_i) + W_ERR'(prod_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_q = st_q.err;

    // R1: a zero midpoint gives zero error.
    assert_quiet_mid_R1: assert property (@(posedge clk) disable iff (rst)
        (en && mid_i == '0 && mid_q == '0) |=> (err_q == '0));

    // R8: an idle cycle leaves the error register alone.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(err_q));

endmodule

// File: rtl/gted_avg.sv
module gted_avg #(
    parameter int N_CH  = 16,
    parameter int W_ERR = 26,
    localparam int LOG_N = (N_CH > 1) ? $clog2(N_CH) : 0,
    localparam int W_SUM = W_ERR + LOG_N,
    localparam int N_NODE = 2 * N_CH - 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [N_CH*W_ERR-1:0]   err_flat,
    output logic                    v_q,
    output logic signed [W_ERR-1:0] avg_q
);
    typedef struct packed {
        logic                    v;
        logic signed [W_ERR-1:0] avg;
    } avg_st_t;

    avg_st_t st_d, st_q;

    // Heap-ordered adder tree: node k sums nodes 2k+1 and 2k+2.
    logic signed [W_SUM-1:0] node [N_NODE];

    for (genvar g = 0; g < N_CH; g++) begin : g_leaf
        assign node[N_CH-1+g] = W_SUM'($signed(err_flat[g*W_ERR +: W_ERR]));
    end

    for (genvar k = 0; k < N_CH - 1; k++) begin : g_node
        assign node[k] = node[2*k+1] + node[2*k+2];
    end

    logic signed [W_SUM-1:0] shifted;
    logic                    all_same;

    always_comb begin
        st_d     = st_q;
        shifted  = node[0] >>> LOG_N;
        st_d.v   = en;
        if (en) begin
            st_d.avg = shifted[W_ERR-1:0];
        end
        all_same = 1'b1;
        for (int c = 1; c < N_CH; c++) begin
            if (err_flat[c*W_ERR +: W_ERR] != err_flat[W_ERR-1:0]) begin
                all_same = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign v_q   = st_q.v;
    assign avg_q = st_q.avg;

    // R2: identical channel errors average to that same error.
    assert_equal_avg_R2: assert property (@(posedge clk) disable iff (rst)
        (en && all_same) |=> (avg_q == $past($signed(err_flat[W_ERR-1:0]))));

endmodule

// File: rtl/gted_loop_filter.sv
module gted_loop_filter #(
    parameter int W_ERR = 26,
    parameter int W_INT = 32,
    parameter int W_OUT = 32,
    parameter int W_SH  = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    v_in,
    input  logic signed [W_ERR-1:0] avg_in,
    input  logic [W_SH-1:0]         kp_shift,
    input  logic [W_SH-1:0]         ki_shift,
    input  logic [W_OUT-1:0]        nominal,
    input  logic                    clr,
    output logic                    out_valid,
    output logic [W_OUT-1:0]        out_step
);
    localparam logic signed [W_INT-1:0] INT_MAX = {1'b0, {(W_INT-1){1'b1}}};
    localparam logic signed [W_INT-1:0] INT_MIN = {1'b1, {(W_INT-1){1'b0}}};

    typedef struct packed {
        logic                    v;
        logic signed [W_INT-1:0] integ;
        logic [W_OUT-1:0]        step;
    } lf_st_t;

    lf_st_t st_d, st_q;

    logic signed [W_INT-1:0] avg_ext, p_term, i_term, integ_new;
    logic signed [W_INT:0]   acc_wide;

    always_comb begin
        st_d     = st_q;
        avg_ext  = W_INT'(avg_in);
        p_term   = avg_ext >>> kp_shift;
        i_term   = avg_ext >>> ki_shift;
        acc_wide = {st_q.integ[W_INT-1], st_q.integ} + {i_term[W_INT-1], i_term};

        if (acc_wide[W_INT] != acc_wide[W_INT-1]) begin
            integ_new = acc_wide[W_INT] ? INT_MIN : INT_MAX;
        end else begin
            integ_new = acc_wide[W_INT-1:0];
        end

        if (clr) begin
            integ_new = '0;
        end else if (!v_in) begin
            integ_new = st_q.integ;
        end

        st_d.integ = integ_new;
        st_d.v     = v_in;
        if (v_in) begin
            st_d.step = nominal + W_OUT'(p_term) + W_OUT'(integ_new);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.v;
    assign out_step  = st_q.step;

    // R6: a clear leaves the integrator at zero.
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (st_q.integ == '0));

    // R8: no update and no clear keeps integrator and step stable.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!v_in && !clr) |=> ($stable(st_q.integ) && $stable(out_step)));

    // R3: saturation holds at the upper limit.
    assert_sat_high_R3: assert property (@(posedge clk) disable iff (rst)
        (v_in && !clr && st_q.integ == INT_MAX && !i_term[W_INT-1])
        |=> (st_q.integ == INT_MAX));

    // R3: saturation holds at the lower limit.
    assert_sat_low_R3: assert property (@(posedge clk) disable iff (rst)
        (v_in && !clr && st_q.integ == INT_MIN && i_term[W_INT-1])
        |=> (st_q.integ == INT_MIN));

endmodule

// File: rtl/gardner_par_loop.sv
module gardner_par_loop #(
    parameter int N_CH   = 16,
    parameter int W_SAMP = 12,
    parameter int W_INT  = 32,
    parameter int W_OUT  = 32,
    localparam int W_ERR = gted_pkg::err_width(W_SAMP),
    localparam int W_SH  = $clog2(W_ERR + 1),
    localparam int W_BUS = N_CH * W_SAMP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [W_BUS-1:0] prev_i,
    input  logic [W_BUS-1:0] prev_q,
    input  logic [W_BUS-1:0] mid_i,
    input  logic [W_BUS-1:0] mid_q,
    input  logic [W_BUS-1:0] cur_i,
    input  logic [W_BUS-1:0] cur_q,
    input  logic [W_SH-1:0]  kp_shift,
    input  logic [W_SH-1:0]  ki_shift,
    input  logic [W_OUT-1:0] nominal_step,
    input  logic             integ_clear,
    output logic             out_valid,
    output logic [W_OUT-1:0] out_step
);
    typedef struct packed {
        logic v1;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [N_CH*W_ERR-1:0]   err_flat;
    logic                    avg_v;
    logic signed [W_ERR-1:0] avg_val;

    initial begin
        assert (gted_pkg::is_pow2(N_CH))
            else $error("channel count must be a power of two");
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        logic signed [W_ERR-1:0] err_c;
        gted_channel #(.W_SAMP(W_SAMP)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .en     (in_valid),
            .prev_i ($signed(prev_i[c*W_SAMP +: W_SAMP])),
            .prev_q ($signed(prev_q[c*W_SAMP +: W_SAMP])),
            .mid_i  ($signed(mid_i[c*W_SAMP +: W_SAMP])),
            .mid_q  ($signed(mid_q[c*W_SAMP +: W_SAMP])),
            .cur_i  ($signed(cur_i[c*W_SAMP +: W_SAMP])),
            .cur_q  ($signed(cur_q[c*W_SAMP +: W_SAMP])),
            .err_q  (err_c)
        );
        assign err_flat[c*W_ERR +: W_ERR] = err_c;
    end

    always_comb begin
        st_d    = st_q;
        st_d.v1 = in_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    gted_avg #(.N_CH(N_CH), .W_ERR(W_ERR)) u_avg (
        .clk      (clk),
        .rst      (rst),
        .en       (st_q.v1),
        .err_flat (err_flat),
        .v_q      (avg_v),
        .avg_q    (avg_val)
    );

    gted_loop_filter #(
        .W_ERR (W_ERR),
        .W_INT (W_INT),
        .W_OUT (W_OUT),
        .W_SH  (W_SH)
    ) u_lf (
        .clk       (clk),
        .rst       (rst),
        .v_in      (avg_v),
        .avg_in    (avg_val),
        .kp_shift  (kp_shift),
        .ki_shift  (ki_shift),
        .nominal   (nominal_step),
        .clr       (integ_clear),
        .out_valid (out_valid),
        .out_step  (out_step)
    );

    // R5: every strobe traces back to an input three edges earlier.
    assert_strobe_latency_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));

endmodule

// File: tb/gardner_par_loop_test.sv
module gardner_par_loop_test;
    localparam int N  = 16;
    localparam int W  = 12;
    localparam int LN = 4;
    localparam int WB = N * W;

    logic clk = 0, rst = 1, in_valid = 0, integ_clear = 0;
    logic [WB-1:0] prev_i = '0, prev_q = '0, mid_i = '0, mid_q = '0, cur_i = '0, cur_q = '0;
    logic [4:0] kp_shift = 5'd2, ki_shift = 5'd6;
    logic [31:0] nominal_step = 32'h4000_0000;
    logic out_valid;
    logic [31:0] out_step;

    gardner_par_loop uut (.*);

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    int pi_[N], pq_[N], mi_[N], mq_[N], ci_[N], cq_[N];
    longint integ_m = 0;
    int clr_at = -100;
    logic [31:0] exp_q[$];
    int due_q[$];
    string tag_q[$];

    localparam longint IMAX = 64'sd2147483647;
    localparam longint IMIN = -64'sd2147483648;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic longint ch_err(input int c);
        return longint'(mi_[c]) * (ci_[c] - pi_[c]) + longint'(mq_[c]) * (cq_[c] - pq_[c]);
    endfunction

    task automatic load_bus();
        for (int c = 0; c < N; c++) begin
            prev_i[c*W +: W] = W'(pi_[c]); prev_q[c*W +: W] = W'(pq_[c]);
            mid_i[c*W +: W]  = W'(mi_[c]); mid_q[c*W +: W]  = W'(mq_[c]);
            cur_i[c*W +: W]  = W'(ci_[c]); cur_q[c*W +: W]  = W'(cq_[c]);
        end
    endtask

    function automatic int rs();
        return int'($urandom_range(0, 4095)) - 2048;
    endfunction

    task automatic fill_random();
        for (int c = 0; c < N; c++) begin
            pi_[c] = rs(); pq_[c] = rs(); mi_[c] = rs();
            mq_[c] = rs(); ci_[c] = rs(); cq_[c] = rs();
        end
    endtask

    task automatic fill_const(input int p, input int m, input int cu);
        for (int c = 0; c < N; c++) begin
            pi_[c] = p; pq_[c] = p; mi_[c] = m; mq_[c] = m; ci_[c] = cu; cq_[c] = cu;
        end
    endtask

    task automatic tick_clear();
        integ_clear = (cyc == clr_at);
    endtask

    task automatic send(input string tag, input bit clr_co);
        longint sum, avg, p, inew, iterm;
        @(negedge clk);
        tick_clear();
        load_bus();
        in_valid = 1;
        sum = 0;
        for (int c = 0; c < N; c++) sum += ch_err(c);
        avg = sum >>> LN;
        p = avg >>> kp_shift;
        iterm = avg >>> ki_shift;
        inew = integ_m + iterm;
        if (inew > IMAX) inew = IMAX;
        if (inew < IMIN) inew = IMIN;
        if (clr_co) begin
            inew = 0;
            clr_at = cyc + 2;
        end
        integ_m = inew;
        exp_q.push_back(32'(longint'(nominal_step) + p + inew));
        due_q.push_back(cyc + 3);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input bit garbage);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_clear();
            in_valid = 0;
            if (garbage) begin
                fill_random();
                load_bus();
            end
        end
    endtask

    task automatic clear_now();
        @(negedge clk);
        clr_at = cyc;
        tick_clear();
        in_valid = 0;
        integ_m = 0;
        idle(4, 0);
    endtask

    // Output monitor: each strobe must match the queue head and its due cycle (R5).
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R5 unexpected strobe", 1, 0);
                end else begin
                    chk(due_q[0] == cyc, "R5 strobe timing", cyc, due_q[0]);
                    chk(out_step == exp_q[0], tag_q[0], out_step, exp_q[0]);
                    void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
                end
            end else if (due_q.size() != 0 && due_q[0] <= cyc) begin
                chk(0, "R5 missing strobe", 0, 1);
                void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R7: reset state
        chk(out_valid == 0, "R7 out_valid", out_valid, 0);
        chk(out_step == 0, "R7 out_step", out_step, 0);

        // R7: zero integrator after reset, R1 zero midpoint gives zero error
        fill_const(700, 0, -300);
        send("R1 zero mid / R7 integ", 0);
        idle(4, 0);

        // R1/R2 directed extremes
        fill_const(2047, -2048, -2048);
        send("R1 max positive error", 0);
        fill_const(2047, 2047, -2048);
        send("R1 max negative error", 0);
        idle(4, 0);

        // R2: sum of -1 must floor to -1
        fill_const(0, 0, 0);
        mi_[3] = 1; pi_[3] = 1; ci_[3] = 0;
        send("R2 floor of -1", 0);
        mi_[3] = 0; mq_[5] = 1; cq_[5] = 1;
        send("R2 floor of +1", 0);
        idle(4, 0);

        // R1/R4/R9: random traffic, bursts and gaps
        for (int k = 0; k < 60; k++) begin
            fill_random();
            send((k % 2) ? "R9 random burst" : "R4 random step", 0);
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)), 0);
        end
        idle(4, 0);

        // R4: other gain settings, including shifts beyond the average width
        kp_shift = 5'd0; ki_shift = 5'd31; nominal_step = 32'hFFFF_FF00;
        for (int k = 0; k < 6; k++) begin fill_random(); send("R4 kp0 ki31", 0); end
        idle(4, 0);
        kp_shift = 5'd30; ki_shift = 5'd3;
        for (int k = 0; k < 6; k++) begin fill_random(); send("R4 kp30 ki3", 0); end
        idle(4, 0);

        // R8: garbage on buses with in_valid low
        idle(8, 1);
        fill_const(100, 50, -100);
        send("R8 idle ignored", 0);
        idle(4, 0);

        // R6: clear while idle
        clear_now();
        fill_const(-200, 300, 400);
        send("R6 after clear", 0);
        idle(4, 0);

        // R3: saturate high then low with ki=0
        kp_shift = 5'd0; ki_shift = 5'd0; nominal_step = 32'h1000_0000;
        fill_const(2047, -2048, -2048);
        for (int k = 0; k < 150; k++) send("R3 saturate high", 0);
        idle(4, 0);
        fill_const(2047, 2047, -2048);
        for (int k = 0; k < 290; k++) send("R3 saturate low", 0);
        idle(4, 0);

        // R6: clear landing on the same edge as an update, with traffic around it
        kp_shift = 5'd3; ki_shift = 5'd4;
        fill_random(); send("R6 before coincident", 0);
        fill_random(); send("R6 coincident clear", 1);
        fill_random(); send("R6 after coincident", 0);
        fill_random(); send("R6 after coincident", 0);
        idle(6, 0);

        chk(exp_q.size() == 0, "R5 outstanding results", exp_q.size(), 0);
        finish_run();
    end
endmodule